// File: doc/BRIEF.md
# Exhaustive Adder Self-Test Controller

This block is a self-test sequencer for a combinational adder under test whose operands are 16 bits wide. After reset it walks the whole operand space, one pair per clock. A single counter supplies both operands. The adder's sum and carry-out come back to the block one cycle after the operands go out. The block compares them against its own 17-bit reference sum. On the first pair that disagrees, the sweep stops and the block raises a fail flag. The failing operands then stay on the operand outputs until reset, so the fault can be read off a hexadecimal display.

A 2-bit fault-selection value passes through the block unchanged to the adder under test. This lets a fault-injectable adder be steered from the same control point. If every pair agrees, the block stops on the all-ones pair and raises a done flag. The operand width is a parameter; the default is 16.

Top module: `adh_top`

## Requirements
- R1: While reset (synchronous, active high) is applied and in the first cycle after it, `op_a` and `op_b` are zero, `running` is 1, and `done` and `fail` are 0.
- R2: The applied pair comes from one counter of width 2*OPW. `op_a` is its upper half and `op_b` its lower half, so `op_b` changes fastest. After the n-th clock edge following reset release, the pair is (n >> OPW, n mod 2^OPW).
- R3: While `running` is 1 and no mismatch has been seen, the counter advances by exactly one per clock. It does not wrap past the all-ones pair.
- R4: The pair applied in one cycle, together with `{carry_in, sum_in}` sampled in that cycle, is checked in the next cycle. The check is against the 17-bit reference `{0,A} + {0,B}`.
- R5: The first mismatch sets `fail` and clears `running` two clock edges after the failing pair was applied. From then on, `op_a`/`op_b` show the failing pair.
- R6: Once `fail` is 1, it stays 1 and `op_a`, `op_b` stay constant until reset.
- R7: When the all-ones pair passes, `done` rises two edges after that pair was applied. For 2^(2*OPW) pairs this is edge 2^(2*OPW)+1. `running` falls at the same edge, and `done` and the all-ones pair then hold until reset.
- R8: `fm_out` always equals `fm_in`, combinationally, in every state.
- R9: A pair whose sum bits are correct but whose carry-out is wrong counts as a mismatch.
- R10: Reset applied after a failure clears `fail` and restarts the sweep from the zero pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fm_in | input | 2 | Fault-selection value to forward |
| sum_in | input | OPW | Sum bits returned by the adder under test |
| carry_in | input | 1 | Carry-out returned by the adder under test |
| op_a | output | OPW | Operand A applied to the adder; failing A once stopped |
| op_b | output | OPW | Operand B applied to the adder; failing B once stopped |
| fm_out | output | 2 | Forwarded fault-selection value |
| running | output | 1 | Sweep in progress |
| done | output | 1 | All pairs passed |
| fail | output | 1 | A mismatch was found |

## Verification
On every cycle, the assertions check the following:
- the counter's single-step advance;
- that each issued pair reaches the compare stage unchanged;
- that a mismatch turns into a failure on the next edge;
- that the failing pair shows up on the operand outputs;
- that the fail and done states stay put.

Only the bench scenarios can show the end-to-end results. Using a reduced operand width, they show where in the sweep each injected fault is caught, the exact edge count to fail or done, the carry-only fault, the forwarding of the fault-selection value, and the restart after reset.

// File: rtl/adh_pkg.sv
package adh_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PASS = 2'd1,
        ST_FAIL = 2'd2
    } adh_state_e;

endpackage

// File: rtl/adh_sweep.sv
module adh_sweep #(
    parameter int OPW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               reload,
    input  logic [2*OPW-1:0]   reload_val,
    output logic [2*OPW-1:0]   cnt,
    output logic               issue
);
    localparam int CW = 2 * OPW;
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          last;
    } sweep_t;

    sweep_t sw_q, sw_d;

    always_comb begin
        sw_d  = sw_q;
        issue = run && !reload && !sw_q.last;
        if (reload) begin
            sw_d.cnt = reload_val;
        end else if (issue) begin
            if (sw_q.cnt == CMAX) begin
                sw_d.last = 1'b1;
            end else begin
                sw_d.cnt = sw_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= '0;
        end else begin
            sw_q <= sw_d;
        end
    end

    assign cnt = sw_q.cnt;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        (issue && sw_q.cnt != CMAX) |=> (sw_q.cnt == $past(sw_q.cnt) + 1'b1)); // R3

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !reload) |=> $stable(sw_q.cnt)); // R6

endmodule

// File: rtl/adh_check.sv
module adh_check #(
    parameter int OPW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cap_en,
    input  logic [OPW-1:0] cap_a,
    input  logic [OPW-1:0] cap_b,
    input  logic [OPW-1:0] cap_sum,
    input  logic           cap_carry,
    output logic           mismatch,
    output logic           pass_last,
    output logic [OPW-1:0] chk_a,
    output logic [OPW-1:0] chk_b
);
    localparam logic [OPW-1:0] OMAX = '1;

    typedef struct packed {
        logic           valid;
        logic [OPW-1:0] a;
        logic [OPW-1:0] b;
        logic [OPW:0]   obs;
    } stage_t;

    stage_t st_q, st_d;
    logic [OPW:0] exp_sum;

    always_comb begin
        st_d       = st_q;
        st_d.valid = cap_en;
        if (cap_en) begin
            st_d.a   = cap_a;
            st_d.b   = cap_b;
            st_d.obs = {cap_carry, cap_sum};
        end
        exp_sum   = {1'b0, st_q.a} + {1'b0, st_q.b};
        mismatch  = st_q.valid && (exp_sum != st_q.obs);
        pass_last = st_q.valid && !mismatch && (st_q.a == OMAX) && (st_q.b == OMAX);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chk_a = st_q.a;
    assign chk_b = st_q.b;

    AST_CAPTURE_SUM: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> (st_q.obs == $past({cap_carry, cap_sum}))); // R4

endmodule

// File: rtl/adh_ctrl.sv
module adh_ctrl (
    input  logic                clk,
    input  logic                rst,
    input  logic                mismatch,
    input  logic                pass_last,
    output adh_pkg::adh_state_e state
);
    import adh_pkg::*;

    adh_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q == ST_RUN) begin
            if (mismatch) begin
                st_d = ST_FAIL;
            end else if (pass_last) begin
                st_d = ST_PASS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_RUN;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q;

    AST_MISMATCH_FAILS: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && mismatch) |=> (st_q == ST_FAIL)); // R5

    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FAIL) |=> (st_q == ST_FAIL)); // R6

    AST_PASS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PASS) |=> (st_q == ST_PASS)); // R7

endmodule

// File: rtl/adh_top.sv
module adh_top #(
    parameter int OPW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     fm_in,
    input  logic [OPW-1:0] sum_in,
    input  logic           carry_in,
    output logic [OPW-1:0] op_a,
    output logic [OPW-1:0] op_b,
    output logic [1:0]     fm_out,
    output logic           running,
    output logic           done,
    output logic           fail
);
    import adh_pkg::*;

    localparam int CW = 2 * OPW;

    adh_state_e     state;
    logic [CW-1:0]  cnt;
    logic           issue;
    logic           mismatch;
    logic           pass_last;
    logic           reload;
    logic [OPW-1:0] chk_a;
    logic [OPW-1:0] chk_b;

    assign reload = mismatch && (state == ST_RUN);

    adh_sweep #(.OPW(OPW)) u_sweep (
        .clk        (clk),
        .rst        (rst),
        .run        (state == ST_RUN),
        .reload     (reload),
        .reload_val ({chk_a, chk_b}),
        .cnt        (cnt),
        .issue      (issue)
    );

    adh_check #(.OPW(OPW)) u_check (
        .clk       (clk),
        .rst       (rst),
        .cap_en    (issue),
        .cap_a     (op_a),
        .cap_b     (op_b),
        .cap_sum   (sum_in),
        .cap_carry (carry_in),
        .mismatch  (mismatch),
        .pass_last (pass_last),
        .chk_a     (chk_a),
        .chk_b     (chk_b)
    );

    adh_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .mismatch  (mismatch),
        .pass_last (pass_last),
        .state     (state)
    );

    assign op_a    = cnt[CW-1:OPW];
    assign op_b    = cnt[OPW-1:0];
    assign fm_out  = fm_in;
    assign running = (state == ST_RUN);
    assign done    = (state == ST_PASS);
    assign fail    = (state == ST_FAIL);

    AST_PAIR_REACHES_CHECK: assert property (@(posedge clk) disable iff (rst)
        issue |=> (chk_a == $past(op_a) && chk_b == $past(op_b))); // R4

    AST_FAIL_SHOWS_PAIR: assert property (@(posedge clk) disable iff (rst)
        $rose(fail) |-> (op_a == $past(chk_a) && op_b == $past(chk_b))); // R5

    AST_ONE_STATUS: assert property (@(posedge clk) disable iff (rst)
        $onehot({running, done, fail})); // R1

endmodule

// File: tb/adh_fault_adder.sv
module adh_fault_adder #(
    parameter int OPW = 16
) (
    input  logic [OPW-1:0] a,
    input  logic [OPW-1:0] b,
    input  logic [1:0]     mode,
    output logic [OPW-1:0] sum,
    output logic           carry
);
    localparam logic [OPW-1:0] OMAX = '1;
    localparam logic [OPW-1:0] TWO  = OPW'(2);
    localparam logic [OPW-1:0] ONE  = OPW'(1);

    logic hit;

    always_comb begin
        {carry, sum} = {1'b0, a} + {1'b0, b};
        case (mode)
            2'd1:    hit = (a == TWO) && (b == TWO);
            2'd2:    hit = (a == OMAX) && (b == ONE);
            2'd3:    hit = (a == OMAX) && (b == OMAX);
            default: hit = 1'b0;
        endcase
        if (hit) begin
            sum[0] = ~sum[0];
        end
    end
endmodule

// File: tb/tb_adh_top.sv
module tb_adh_top;
    localparam int TB_W   = 4;
    localparam time CLK_T = 10ns;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      fm_in = 2'd0;
    logic [TB_W-1:0] sum_in;
    logic            carry_in;
    logic            model_carry;
    logic            cflip_en = 1'b0;
    logic [TB_W-1:0] op_a, op_b;
    logic [1:0]      fm_out;
    logic            running, done, fail;

    int checks = 0;
    int failures = 0;

    always #(CLK_T / 2) clk = ~clk;

    adh_top #(.OPW(TB_W)) dut (
        .clk(clk), .rst(rst), .fm_in(fm_in), .sum_in(sum_in), .carry_in(carry_in),
        .op_a(op_a), .op_b(op_b), .fm_out(fm_out),
        .running(running), .done(done), .fail(fail)
    );

    adh_fault_adder #(.OPW(TB_W)) u_model (
        .a(op_a), .b(op_b), .mode(fm_out), .sum(sum_in), .carry(model_carry)
    );

    // Carry-only fault on pair (3,0) when enabled
    assign carry_in = model_carry ^ (cflip_en && op_a == 4'd3 && op_b == 4'd0);

    // row: {mode[2], exp_fail, exp_a[4], exp_b[4], exp_edges[10]}
    localparam logic [20:0] VECS [4] = '{
        {2'd0, 1'b0, 4'd15, 4'd15, 10'd257},
        {2'd1, 1'b1, 4'd2,  4'd2,  10'd36},
        {2'd2, 1'b1, 4'd15, 4'd1,  10'd243},
        {2'd3, 1'b1, 4'd15, 4'd15, 10'd257}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_sweep(output int edges);
        edges = 0;
        while (!(fail || done) && edges < 400) begin
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
    endtask

    initial begin
        #(CLK_T * 150000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int edges;

        // R1: state during reset
        @(negedge clk);
        @(negedge clk);
        check(op_a == 0 && op_b == 0, "R1", "ops in reset", {op_a, op_b}, 0);
        check(running && !done && !fail, "R1", "status in reset",
              {running, done, fail}, 3'b100);

        // R8: forwarding of fault selection in every value
        for (int m = 0; m < 4; m++) begin
            fm_in = 2'(m);
            #1;
            check(fm_out == 2'(m), "R8", "fm forward", fm_out, m);
        end
        fm_in = 2'd0;

        // R2 / R3: ordering and single step per clock
        rst = 1'b0;
        for (int n = 1; n <= 20; n++) begin
            @(posedge clk);
            @(negedge clk);
            check(op_a == 4'(n >> 4) && op_b == 4'(n & 15), "R2_R3",
                  "pair after edge", {op_a, op_b}, n);
        end

        // Table of fault modes (R4, R5, R7)
        foreach (VECS[i]) begin
            fm_in = VECS[i][20:19];
            do_reset();
            run_sweep(edges);
            check(fail == VECS[i][18], "R5", "fail flag", fail, VECS[i][18]);
            check(done == !VECS[i][18], "R7", "done flag", done, !VECS[i][18]);
            check(edges == int'(VECS[i][9:0]), "R4", "edges to stop", edges, VECS[i][9:0]);
            check(op_a == VECS[i][17:14] && op_b == VECS[i][13:10], "R5",
                  "stopped pair", {op_a, op_b}, VECS[i][17:10]);
            check(!running, "R7", "running low after stop", running, 0);
        end

        // R6: fail holds with constant pair
        fm_in = 2'd1;
        do_reset();
        run_sweep(edges);
        repeat (40) @(negedge clk);
        check(fail && !running && !done, "R6", "fail held", {running, done, fail}, 3'b001);
        check(op_a == 2 && op_b == 2, "R6", "pair held", {op_a, op_b}, 8'h22);

        // R10: reset after failure restarts at zero
        do_reset();
        check(!fail && running, "R10", "status after reset", {running, fail}, 2'b10);
        check(op_a == 0 && op_b == 0, "R10", "pair restarts", {op_a, op_b}, 0);
        @(posedge clk);
        @(negedge clk);
        check(op_b == 1 && op_a == 0, "R10", "first step", {op_a, op_b}, 1);

        // R7: done holds at all-ones pair
        fm_in = 2'd0;
        do_reset();
        run_sweep(edges);
        repeat (30) @(negedge clk);
        check(done && !fail, "R7", "done held", {done, fail}, 2'b10);
        check(op_a == 15 && op_b == 15, "R7", "pair held at max", {op_a, op_b}, 8'hFF);

        // R9: carry-only fault on pair (3,0) -> index 48, stop at edge 50
        cflip_en = 1'b1;
        do_reset();
        run_sweep(edges);
        check(fail, "R9", "carry fault detected", fail, 1);
        check(edges == 50, "R9", "edges to carry fault", edges, 50);
        check(op_a == 3 && op_b == 0, "R9", "carry fault pair", {op_a, op_b}, 8'h30);
        cflip_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule